// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block is the software-visible register file of an I/O interrupt controller. A host bus carries a byte offset, read and write strobes, a byte-count size and 32-bit data. Three offsets are decoded. The first holds a select value. The second is a data window onto whichever internal register the select value names. The third takes end-of-interrupt writes, which are handed on as a vector to the delivery logic.

The internal registers are a 4-bit identifier, a read-only version word, an arbitration alias of the identifier, and one 64-bit redirection entry per interrupt pin. Each entry is reached as a low and a high 32-bit half. Two entry bits are owned by the delivery logic and cannot be written from the bus. The first is a delivery-busy flag, which mirrors an input. The second is a remote-pending flag, which is set and cleared by inputs. Whenever an entry is written in edge mode, its remote-pending flag is dropped.

All entries are exported in parallel. A strobe with the pin number marks every accepted table write, so that downstream routing can refresh itself.

Top module: `irq_redir_regs`

## Requirements
- R1: Only offset bits 7:0 are decoded: select at 0x00, window at 0x10, end-of-interrupt at 0x40. Higher offset bits alias.
- R2: Window reads return zero and window writes do nothing unless `bus_size` is 4, where `bus_size` gives the access width in bytes.
- R3: Select value 0 is the identifier register, which is writable in bits 27:24 only. Select value 2 reads the same word. Writes through select value 2 are dropped.
- R4: Select value 1 reads VERSION in bits 7:0 and NPINS-1 in bits 23:16, and ignores writes.
- R5: Pin p's entry bits 31:0 sit at select value 0x10+2p and bits 63:32 at 0x11+2p.
- R6: Select values 3 to 0x0F, and values past the last entry, read zero, and writes through them change nothing and raise no strobe.
- R7: Entry bit 12 always equals `dstat_in[p]`. Bit 14 keeps its value across a table write regardless of the written data, unless R8 applies.
- R8: After any table write, if entry bit 15 (trigger, 0 = edge) is 0, bit 14 is 0. This holds even if the write touched only the high half.
- R9: Without a table write, `pend_clr[p]` clears bit 14, and otherwise `pend_set[p]` sets it.
- R10: When VERSION is 0x20, a 4-byte write at offset 0x40 raises `eoi_req` for the next cycle with `eoi_vec` = write data bits 7:0. Otherwise the write is ignored.
- R11: Each accepted table write raises `tbl_chg` for the next cycle, with `tbl_chg_pin` naming the pin.
- R12: Reset leaves every entry at 0x0000_0000_0001_0000 (masked), with select 0 and identifier 0.
- R13: The select register reads back in bits 7:0 and is written from data bits 7:0, at any access size.
- R14: VERSION may only be 0x11 or 0x20. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_rd` is high |
| dstat_in | input | NPINS | Delivery-busy flag for each pin |
| pend_set | input | NPINS | Set remote-pending for each pin |
| pend_clr | input | NPINS | Clear remote-pending for each pin |
| tbl_flat | output | 64*NPINS | All entries, pin p at bits 64p+63:64p |
| tbl_chg | output | 1 | Table-update strobe |
| tbl_chg_pin | output | clog2(NPINS) | Pin of the last table update |
| eoi_req | output | 1 | End-of-interrupt request |
| eoi_vec | output | 8 | End-of-interrupt vector |

## Verification
The hardest state to reach is a set remote-pending flag colliding with a table write. The flag can only be raised through `pend_set`. The bench therefore pulses that input first, then writes the low half with level and edge trigger values, and writes the high half of an edge entry. After each write it reads the entry back through the window. The ignored-EOI path needs a second instance built with version 0x11, which shares the bus with the first.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;

  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;

  localparam int B_DSTAT = 12;
  localparam int B_RPEND = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;

  localparam int ID_LSB = 24;
  localparam int ID_W   = 4;

  localparam logic [63:0] ENTRY_RST = 64'(1) << B_MASK;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_ID   = 2'd1,
    WIN_VER  = 2'd2,
    WIN_TBL  = 2'd3
  } win_kind_e;
endpackage

// File: rtl/irq_redir_hostif.sv
module irq_redir_hostif
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int PIN_W = $clog2(NPINS),
  localparam int TBL_END = 16 + 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ofs_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [2:0]       size_i,
  input  logic [7:0]       wbyte_i,
  output logic [7:0]       sel_o,
  output win_kind_e        kind_o,
  output logic [PIN_W-1:0] pin_o,
  output logic             hi_o,
  output logic             win_wr_o,
  output logic             win_rd_o,
  output logic             sel_rd_o,
  output logic             eoi_wr_o
);
  logic [7:0] sel_q, sel_d;
  logic       sel_en;
  logic       full;
  logic [7:0] rel;

  assign full   = (size_i == 3'd4);
  assign sel_en = wr_i && (ofs_i == OFS_SEL);

  always_comb begin
    sel_d = sel_q;
    if (sel_en) sel_d = wbyte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 8'h00;
    else        sel_q <= sel_d;
  end

  assign rel = sel_q - IDX_TBL;

  always_comb begin
    kind_o = WIN_NONE;
    if (sel_q == IDX_ID || sel_q == IDX_ARB)                     kind_o = WIN_ID;
    else if (sel_q == IDX_VER)                                   kind_o = WIN_VER;
    else if (sel_q >= IDX_TBL && {1'b0, sel_q} < 9'(TBL_END))    kind_o = WIN_TBL;
  end

  assign pin_o    = rel[PIN_W:1];
  assign hi_o     = sel_q[0];
  assign sel_o    = sel_q;
  assign win_wr_o = wr_i && full && (ofs_i == OFS_WIN);
  assign win_rd_o = rd_i && full && (ofs_i == OFS_WIN);
  assign sel_rd_o = rd_i && (ofs_i == OFS_SEL);
  assign eoi_wr_o = wr_i && full && (ofs_i == OFS_EOI);

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && ofs_i == OFS_SEL) |=> $stable(sel_o)); // R13
endmodule

// File: rtl/irq_redir_ident.sv
module irq_redir_ident
  import irq_redir_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h20,
  parameter int NPINS = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [ID_W-1:0] id_i,
  output logic [31:0]     id_word_o,
  output logic [31:0]     ver_word_o
);
  logic [ID_W-1:0] id_q, id_d;

  always_comb begin
    id_d = id_q;
    if (we_i) id_d = id_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else        id_q <= id_d;
  end

  assign id_word_o  = 32'(id_q) << ID_LSB;
  assign ver_word_o = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

  AST_ID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(id_word_o)); // R3
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic        hi_i,
  input  logic [31:0] wdata_i,
  input  logic        dstat_i,
  input  logic        pset_i,
  input  logic        pclr_i,
  output logic [63:0] ent_o
);
  logic [63:0] body_q, body_d;
  logic        pend_q, pend_d;

  always_comb begin
    body_d = body_q;
    if (we_i) begin
      if (hi_i) body_d = {wdata_i, body_q[31:0]};
      else      body_d = {body_q[63:32], wdata_i};
    end
    body_d[B_DSTAT] = 1'b0;
    body_d[B_RPEND] = 1'b0;
  end

  always_comb begin
    pend_d = pend_q;
    if (we_i && !body_d[B_TRIG]) pend_d = 1'b0;
    else if (!we_i && pclr_i)    pend_d = 1'b0;
    else if (!we_i && pset_i)    pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q <= ENTRY_RST;
      pend_q <= 1'b0;
    end else begin
      body_q <= body_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    ent_o          = body_q;
    ent_o[B_DSTAT] = dstat_i;
    ent_o[B_RPEND] = pend_q;
  end

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ent_o[B_TRIG] || !ent_o[B_RPEND])); // R8
  AST_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (!ent_o[B_TRIG] || ent_o[B_RPEND] == $past(ent_o[B_RPEND]))); // R7
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && pclr_i) |=> !ent_o[B_RPEND]); // R9
endmodule

// File: rtl/irq_redir_eoi.sv
module irq_redir_eoi #(
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_i,
  input  logic [7:0] vec_i,
  output logic       req_o,
  output logic [7:0] vec_o
);
  generate
    if (VERSION == 8'h20) begin : g_eoi
      logic       req_q, req_d;
      logic [7:0] vec_q, vec_d;

      always_comb begin
        req_d = hit_i;
        vec_d = vec_q;
        if (hit_i) vec_d = vec_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_q <= 1'b0;
          vec_q <= 8'h00;
        end else begin
          req_q <= req_d;
          vec_q <= vec_d;
        end
      end

      assign req_o = req_q;
      assign vec_o = vec_q;

      AST_EOI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(hit_i)); // R10
      AST_EOI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (vec_o == $past(vec_i))); // R10
    end else begin : g_no_eoi
      logic unused_eoi;
      assign unused_eoi = clk ^ rst_n ^ hit_i ^ (^vec_i);
      assign req_o = 1'b0;
      assign vec_o = 8'h00;
    end
  endgenerate
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 12,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [2:0]               bus_size,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NPINS-1:0]         dstat_in,
  input  logic [NPINS-1:0]         pend_set,
  input  logic [NPINS-1:0]         pend_clr,
  output logic [NPINS*64-1:0]      tbl_flat,
  output logic                     tbl_chg,
  output logic [$clog2(NPINS)-1:0] tbl_chg_pin,
  output logic                     eoi_req,
  output logic [7:0]               eoi_vec
);
  localparam int PIN_W = $clog2(NPINS);

  if (VERSION != 8'h11 && VERSION != 8'h20) begin : g_bad_version
    $error("irq_redir_regs: VERSION must be 8'h11 or 8'h20"); // R14
  end

  logic unused_hi;
  assign unused_hi = ^bus_addr[ADDR_W-1:8];

  logic [7:0]       sel;
  win_kind_e        kind;
  logic [PIN_W-1:0] pin;
  logic             hi, win_wr, win_rd, sel_rd, eoi_wr;
  logic [31:0]      id_word, ver_word;
  logic [NPINS-1:0] tbl_we;
  logic [63:0]      ent [NPINS];

  irq_redir_hostif #(.NPINS(NPINS)) u_hostif (
    .clk      (clk),
    .rst_n    (rst_n),
    .ofs_i    (bus_addr[7:0]),
    .wr_i     (bus_wr),
    .rd_i     (bus_rd),
    .size_i   (bus_size),
    .wbyte_i  (bus_wdata[7:0]),
    .sel_o    (sel),
    .kind_o   (kind),
    .pin_o    (pin),
    .hi_o     (hi),
    .win_wr_o (win_wr),
    .win_rd_o (win_rd),
    .sel_rd_o (sel_rd),
    .eoi_wr_o (eoi_wr)
  );

  irq_redir_ident #(.VERSION(VERSION), .NPINS(NPINS)) u_ident (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (win_wr && sel == IDX_ID),
    .id_i       (bus_wdata[ID_LSB +: ID_W]),
    .id_word_o  (id_word),
    .ver_word_o (ver_word)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign tbl_we[p] = win_wr && (kind == WIN_TBL) && (pin == PIN_W'(p));

    irq_redir_entry u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (tbl_we[p]),
      .hi_i    (hi),
      .wdata_i (bus_wdata),
      .dstat_i (dstat_in[p]),
      .pset_i  (pend_set[p]),
      .pclr_i  (pend_clr[p]),
      .ent_o   (ent[p])
    );

    assign tbl_flat[p*64 +: 64] = ent[p];
  end

  irq_redir_eoi #(.VERSION(VERSION)) u_eoi (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_i (eoi_wr),
    .vec_i (bus_wdata[7:0]),
    .req_o (eoi_req),
    .vec_o (eoi_vec)
  );

  // table-update strobe
  logic             chg_q, chg_d;
  logic [PIN_W-1:0] chg_pin_q, chg_pin_d;

  always_comb begin
    chg_d     = |tbl_we;
    chg_pin_d = chg_pin_q;
    if (|tbl_we) chg_pin_d = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q     <= 1'b0;
      chg_pin_q <= '0;
    end else begin
      chg_q     <= chg_d;
      chg_pin_q <= chg_pin_d;
    end
  end

  assign tbl_chg     = chg_q;
  assign tbl_chg_pin = chg_pin_q;

  // read mux
  always_comb begin
    bus_rdata = 32'h0;
    if (sel_rd) begin
      bus_rdata = {24'h0, sel};
    end else if (win_rd) begin
      case (kind)
        WIN_ID:  bus_rdata = id_word;
        WIN_VER: bus_rdata = ver_word;
        WIN_TBL: bus_rdata = hi ? ent[pin][63:32] : ent[pin][31:0];
        default: bus_rdata = 32'h0;
      endcase
    end
  end

  AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbl_we)); // R5
  AST_CHG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_chg |-> $past(win_wr && kind == WIN_TBL)); // R11
  AST_SHORT_NO_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size != 3'd4) |=> !tbl_chg); // R2
endmodule

// File: tb/irq_redir_regs_bench.sv
module irq_redir_regs_bench;
  localparam int NP = 24;

  typedef struct packed {
    logic        wr;
    logic [11:0] adr;
    logic [2:0]  sz;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 3'd4, 32'h0,        32'h0000_0000, 4'd12}, // R12 select reset
    '{1'b1, 12'h000, 3'd1, 32'h0000_0001, 32'h0,        4'd13}, // R13 byte write of select
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0017_0020, 4'd4 }, // R4 version word
    '{1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0,        4'd4 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0017_0020, 4'd4 }, // R4 write ignored
    '{1'b1, 12'h000, 3'd4, 32'h0,        32'h0,         4'd3 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0000_0000, 4'd12}, // R12 identifier reset
    '{1'b1, 12'h010, 3'd4, 32'hAF00_0000, 32'h0,        4'd3 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0F00_0000, 4'd3 }, // R3 identifier field
    '{1'b1, 12'h000, 3'd4, 32'h2,        32'h0,         4'd3 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0F00_0000, 4'd3 }, // R3 alias reads
    '{1'b1, 12'h010, 3'd4, 32'h0300_0000, 32'h0,        4'd3 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0F00_0000, 4'd3 }, // R3 alias write dropped
    '{1'b1, 12'h000, 3'd4, 32'h10,       32'h0,         4'd12},
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0001_0000, 4'd12}, // R12 masked entry
    '{1'b1, 12'h010, 3'd4, 32'h0000_A031, 32'h0,        4'd5 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0000_A031, 4'd5 }, // R5 low half
    '{1'b1, 12'h000, 3'd4, 32'h11,       32'h0,         4'd5 },
    '{1'b1, 12'h010, 3'd4, 32'h5A00_0000, 32'h0,        4'd5 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h5A00_0000, 4'd5 }, // R5 high half
    '{1'b1, 12'h000, 3'd4, 32'h13,       32'h0,         4'd5 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0000_0000, 4'd5 }, // R5 pin 1 untouched
    '{1'b1, 12'h100, 3'd4, 32'h3F,       32'h0,         4'd1 },
    '{1'b0, 12'h200, 3'd4, 32'h0,        32'h0000_003F, 4'd1 }, // R1 select alias
    '{1'b1, 12'h310, 3'd4, 32'h7700_0000, 32'h0,        4'd1 },
    '{1'b0, 12'h510, 3'd4, 32'h0,        32'h7700_0000, 4'd1 }, // R1 window alias
    '{1'b1, 12'h000, 3'd4, 32'h40,       32'h0,         4'd6 },
    '{1'b1, 12'h010, 3'd4, 32'h1234_5678, 32'h0,        4'd6 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0000_0000, 4'd6 }, // R6 past table
    '{1'b1, 12'h000, 3'd4, 32'h05,       32'h0,         4'd6 },
    '{1'b0, 12'h010, 3'd4, 32'h0,        32'h0000_0000, 4'd6 }, // R6 gap index
    '{1'b1, 12'h000, 3'd4, 32'h10,       32'h0,         4'd2 },
    '{1'b0, 12'h010, 3'd2, 32'h0,        32'h0000_0000, 4'd2 }, // R2 short read
    '{1'b0, 12'h000, 3'd1, 32'h0,        32'h0000_0010, 4'd13}  // R13 select at size 1
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [11:0]     bus_addr;
  logic            bus_wr, bus_rd;
  logic [2:0]      bus_size;
  logic [31:0]     bus_wdata, bus_rdata, rdata_b;
  logic [NP-1:0]   dstat_in, pend_set, pend_clr;
  logic [NP*64-1:0] tbl_flat, tbl_flat_b;
  logic            tbl_chg, tbl_chg_b, eoi_req, eoi_req_b;
  logic [4:0]      tbl_chg_pin, tbl_chg_pin_b;
  logic [7:0]      eoi_vec, eoi_vec_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_redir_regs u_irq_redir_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dstat_in(dstat_in), .pend_set(pend_set), .pend_clr(pend_clr),
    .tbl_flat(tbl_flat), .tbl_chg(tbl_chg), .tbl_chg_pin(tbl_chg_pin),
    .eoi_req(eoi_req), .eoi_vec(eoi_vec)
  );

  irq_redir_regs #(.VERSION(8'h11)) u_old (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .dstat_in(dstat_in), .pend_set(pend_set), .pend_clr(pend_clr),
    .tbl_flat(tbl_flat_b), .tbl_chg(tbl_chg_b), .tbl_chg_pin(tbl_chg_pin_b),
    .eoi_req(eoi_req_b), .eoi_vec(eoi_vec_b)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_rd = 1'b1; bus_wr = 1'b0;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_entry_lo(output logic [31:0] d);
    bwr(12'h000, 3'd4, 32'h10);
    brd(12'h010, 3'd4, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_size = 3'd4;
    bus_wdata = '0; dstat_in = '0; pend_set = '0; pend_clr = '0;
    repeat (3) @(negedge clk);
    chk("R12 tbl_flat pin0 after reset", tbl_flat[63:0], 64'h1_0000);
    chk("R12 tbl_flat pin23 after reset", tbl_flat[23*64 +: 64], 64'h1_0000);
    chk("R12 no strobes in reset", {62'b0, tbl_chg, eoi_req}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        bwr(VEC[i].adr, VEC[i].sz, VEC[i].dat);
      end else begin
        brd(VEC[i].adr, VEC[i].sz, d);
        checks++;
        if (d !== VEC[i].exp) begin
          fails++;
          $display("FAIL vector %0d R%0d actual=%h expected=%h", i, VEC[i].req, d, VEC[i].exp);
        end
      end
    end

    // R2 short write ignored, no strobe
    bwr(12'h000, 3'd4, 32'h10);
    bwr(12'h010, 3'd2, 32'h0000_FFFF);
    chk("R2 short write no strobe", {63'b0, tbl_chg}, 64'h0);
    brd(12'h010, 3'd4, d);
    chk("R2 short write no effect", d, 32'h0000_A031);

    // R11 strobe after a table write to pin 5 high half
    bwr(12'h000, 3'd4, 32'h1B);
    bwr(12'h010, 3'd4, 32'hC300_0000);
    chk("R11 strobe raised", {63'b0, tbl_chg}, 64'h1);
    chk("R11 strobe pin", {59'b0, tbl_chg_pin}, 64'd5);
    chk("R5 tbl_flat pin5", tbl_flat[5*64 +: 64], 64'hC300_0000_0001_0000);
    @(negedge clk);
    chk("R11 strobe one cycle", {63'b0, tbl_chg}, 64'h0);
    bwr(12'h000, 3'd4, 32'h60);
    bwr(12'h010, 3'd4, 32'h1);
    chk("R6 no strobe past table", {63'b0, tbl_chg}, 64'h0);

    // R7 read-only bits ignore written ones
    bwr(12'h000, 3'd4, 32'h10);
    bwr(12'h010, 3'd4, 32'h0001_D031);
    brd(12'h010, 3'd4, d);
    chk("R7 written ro bits dropped", d, 32'h0001_8031);

    // R9 set pending
    @(negedge clk); pend_set[0] = 1'b1;
    @(negedge clk); pend_set[0] = 1'b0;
    brd(12'h010, 3'd4, d);
    chk("R9 pend set", d, 32'h0001_C031);

    // R7 level write keeps pending
    bwr(12'h010, 3'd4, 32'h0000_8031);
    brd(12'h010, 3'd4, d);
    chk("R7 level write keeps pending", d, 32'h0000_C031);

    // R8 edge write clears pending
    bwr(12'h010, 3'd4, 32'h0000_4031);
    brd(12'h010, 3'd4, d);
    chk("R8 edge write clears pending", d, 32'h0000_0031);

    // R8 high-half write on an edge entry clears pending
    @(negedge clk); pend_set[0] = 1'b1;
    @(negedge clk); pend_set[0] = 1'b0;
    brd(12'h010, 3'd4, d);
    chk("R9 pend set on edge entry", d, 32'h0000_4031);
    bwr(12'h000, 3'd4, 32'h11);
    bwr(12'h010, 3'd4, 32'h0100_0000);
    rd_entry_lo(d);
    chk("R8 high write clears pending", d, 32'h0000_0031);

    // R9 clear pending
    @(negedge clk); pend_set[0] = 1'b1;
    @(negedge clk); pend_set[0] = 1'b0; pend_clr[0] = 1'b1;
    @(negedge clk); pend_clr[0] = 1'b0;
    brd(12'h010, 3'd4, d);
    chk("R9 pend clear", d, 32'h0000_0031);

    // R7 delivery flag mirrors input
    dstat_in[0] = 1'b1;
    brd(12'h010, 3'd4, d);
    chk("R7 delivery flag", d, 32'h0000_1031);
    chk("R7 delivery flag on tbl_flat", {63'b0, tbl_flat[12]}, 64'h1);
    dstat_in[0] = 1'b0;

    // R10 end of interrupt
    bwr(12'h040, 3'd4, 32'h0000_01A5);
    chk("R10 eoi request", {63'b0, eoi_req}, 64'h1);
    chk("R10 eoi vector", {56'b0, eoi_vec}, 64'hA5);
    chk("R10 ignored when version 0x11", {63'b0, eoi_req_b}, 64'h0);
    @(negedge clk);
    chk("R10 eoi one cycle", {63'b0, eoi_req}, 64'h0);
    bwr(12'h040, 3'd2, 32'h0000_0033);
    chk("R10 short eoi ignored", {63'b0, eoi_req}, 64'h0);
    bwr(12'h000, 3'd4, 32'h1);
    @(negedge clk);
    bus_addr = 12'h010; bus_size = 3'd4; bus_rd = 1'b1;
    #1;
    chk("R4 version 0x11 word", rdata_b, 32'h0017_0011);
    bus_rd = 1'b0;

    // R12 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    brd(12'h000, 3'd4, d);
    chk("R12 select cleared", d, 32'h0);
    brd(12'h010, 3'd4, d);
    chk("R12 identifier cleared", d, 32'h0);
    chk("R12 pin0 masked again", tbl_flat[63:0], 64'h1_0000);
    chk("R12 pin5 masked again", tbl_flat[5*64 +: 64], 64'h1_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule